// File: doc/BRIEF.md
# Two-Stage Overflow Watchdog Timer

This peripheral watches for a stalled system. Software programs a 12-bit period, clears the elapsed count and turns counting on through a small 32-bit register interface clocked by the bus clock. The elapsed counter itself runs on a separate oscillator clock. Each period lasts (N+1)·2^PRESCALE_LOG2 oscillator cycles, where N is the programmed setting. With the default prescale exponent of 20, a setting of 0 gives about a million oscillator cycles.

When a period runs out without a refresh, the block raises an interrupt. If a second full period then runs out with still no refresh, the block drives a reset request pulse to the system and stops counting. Software keeps the system alive by writing a one to the clear bit of the interrupt register. That write drops the interrupt at once and restarts both the count and the two-stage sequence.

Writes to the control, setting and count registers reach the oscillator domain through toggle synchronizers. They take effect within a bounded latency. A shorter prescale exponent lets a simulation cover every stage in a few thousand cycles.

Top module: `two_stage_wdt`

## Requirements
- R1: After module reset, every register reads zero and both `irq_o` and `rst_req_o` are low.
- R2: The register word index is `bus_addr[3:2]`. Index 0 is control, and bit 0 is the enable. Index 1 is the setting, held in bits [31:20]; bits [19:0] read as zero. Index 2 is the count register and reads zero. Index 3 is the interrupt register, whose bit 0 is the interrupt status.
- R3: Once enabled with setting N, the first overflow occurs (N+1)·2^PRESCALE_LOG2 oscillator cycles after the enable takes effect.
- R4: The first overflow sets the status bit and drives `irq_o` high, and both stay high until they are cleared.
- R5: A second consecutive overflow, with no refresh in between, drives `rst_req_o` high for exactly RST_PULSE_LEN oscillator cycles, starting 2·(N+1)·2^PRESCALE_LOG2 oscillator cycles after the enable.
- R6: Writing 1 to bit 0 of the interrupt register clears the status and `irq_o` on the next bus edge, and restarts both the count and the overflow sequence. Writing 0 to that bit has no effect.
- R7: Any write to the count register restarts the elapsed count from zero.
- R8: Writes to the control, setting and count registers take effect within 6 oscillator cycles plus 9 bus cycles.
- R9: Once the enable is set, a write of 0 to the control register leaves the enable set and counting running.
- R10: After the reset request pulse, counting halts, and no further overflow or pulse occurs until the next module reset.
- R11: Asserting module reset while counting clears every register and stops counting.
- R12: While the enable is clear, no overflow, interrupt or reset request occurs, whatever the setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register interface clock |
| clk_osc | input | 1 | Oscillator clock that drives the elapsed counter |
| rst_n | input | 1 | Active-low module reset for both domains |
| bus_wr_en | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt after the first overflow |
| rst_req_o | output | 1 | System reset request pulse after the second overflow |

## Verification
The main timing function is swept over settings 0 to 5 and 31 under a small prescale. Each run times the interrupt, the reset pulse and its width against arithmetic bounds, so an off-by-one in the period length or a missing stage falls outside the window. A run with periodic refreshes shows that a live system never sees an interrupt. Ending the refreshes, and then clearing once between the two stages, separates a refresh that restarts the sequence from one that only drops the interrupt. Separate runs cover a mid-period count write, a disable write after start, an idle block with no enable, and a module reset mid-count, which expose a counter that ignores these inputs.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

  localparam int DATA_W  = 32;
  localparam int SET_W   = 12;
  localparam int SET_LSB = DATA_W - SET_W;

  // word index of each register (bus_addr[3:2])
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_SET  = 2'd1,
    REG_CNT  = 2'd2,
    REG_INT  = 2'd3
  } wdt_reg_e;

  // bus-to-oscillator crossing channels
  localparam int CH_CTRL = 0;
  localparam int CH_SET  = 1;
  localparam int CH_CNT  = 2;
  localparam int CH_CLR  = 3;
  localparam int NUM_CH  = 4;

  localparam int EN_BIT  = 0;
  localparam int CLR_BIT = 0;

  function automatic logic [SET_W-1:0] set_field(input logic [DATA_W-1:0] w);
    return w[DATA_W-1:SET_LSB];
  endfunction

  function automatic logic [DATA_W-1:0] set_word(input logic [SET_W-1:0] s);
    return {s, {SET_LSB{1'b0}}};
  endfunction

endpackage

// File: rtl/wdt_xfer.sv
`timescale 1ns/1ps
// Single-event transfer between clock domains using a toggle
module wdt_xfer #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic dst_clk,
  input  logic rst_n,
  input  logic src_pulse,
  output logic dst_pulse
);
  logic              tog_q;
  logic [STAGES-1:0] sync_q;
  logic              seen_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_q ^ src_pulse;
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      seen_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tog_q};
      seen_q <= sync_q[STAGES-1];
    end
  end

  assign dst_pulse = sync_q[STAGES-1] ^ seen_q;
endmodule

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
// Bus-side register file: shadows, status flag, read mux, crossing requests
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ovf_evt,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              en_sh,
  output logic [SET_W-1:0]  set_sh,
  output logic [NUM_CH-1:0] ch_pulse
);
  logic     in_range;
  logic     hit;
  wdt_reg_e idx;
  logic     status_q;
  logic     unused_bits;

  assign in_range    = (addr >> 4) == '0;
  assign idx         = wdt_reg_e'(addr[3:2]);
  assign hit         = wr_en && in_range;
  assign unused_bits = ^{addr[1:0], wdata[SET_LSB-1:1]};

  always_comb begin
    ch_pulse          = '0;
    ch_pulse[CH_CTRL] = hit && (idx == REG_CTRL);
    ch_pulse[CH_SET]  = hit && (idx == REG_SET);
    ch_pulse[CH_CNT]  = hit && (idx == REG_CNT);
    ch_pulse[CH_CLR]  = hit && (idx == REG_INT) && wdata[CLR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_sh  <= 1'b0;
      set_sh <= '0;
    end else begin
      if (ch_pulse[CH_CTRL]) en_sh  <= en_sh | wdata[EN_BIT];
      if (ch_pulse[CH_SET])  set_sh <= set_field(wdata);
    end
  end

  // a clear write wins over an overflow arriving in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 status_q <= 1'b0;
    else if (ch_pulse[CH_CLR])  status_q <= 1'b0;
    else if (ovf_evt)           status_q <= 1'b1;
  end

  assign irq = status_q;

  always_comb begin
    rdata = '0;
    if (in_range) begin
      case (idx)
        REG_CTRL: rdata[EN_BIT]  = en_sh;
        REG_SET:  rdata          = set_word(set_sh);
        REG_CNT:  rdata          = '0;
        REG_INT:  rdata[CLR_BIT] = status_q;
        default:  rdata          = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
// Oscillator-domain counter, two-stage overflow sequence and reset pulse
module wdt_core
  import wdt_pkg::*;
#(
  parameter int PRESCALE_LOG2 = 20,
  parameter int RST_PULSE_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_ctrl,
  input  logic             ld_set,
  input  logic             ld_cnt,
  input  logic             refresh,
  input  logic             en_in,
  input  logic [SET_W-1:0] set_in,
  output logic             ovf_first,
  output logic             ovf_second,
  output logic             stage,
  output logic             halted,
  output logic             rst_req
);
  localparam int CNT_W = SET_W + PRESCALE_LOG2;
  localparam int PW    = $clog2(RST_PULSE_LEN + 1);

  // last count value of a period: (s+1)*2^PRESCALE_LOG2 - 1
  function automatic logic [CNT_W-1:0] last_count(input logic [SET_W-1:0] s);
    return {s, {PRESCALE_LOG2{1'b1}}};
  endfunction

  logic             en_q;
  logic [SET_W-1:0] set_q;
  logic [CNT_W-1:0] cnt_q;
  logic             stage_q;
  logic             halt_q;
  logic [PW-1:0]    pulse_q;
  logic             counting;
  logic             at_last;

  assign counting   = en_q && !halt_q;
  assign at_last    = counting && (cnt_q >= last_count(set_q));
  assign ovf_first  = at_last && !stage_q && !refresh;
  assign ovf_second = at_last &&  stage_q && !refresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      set_q <= '0;
    end else begin
      if (ld_ctrl) en_q  <= en_q | en_in;
      if (ld_set)  set_q <= set_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (refresh || ld_cnt || at_last) cnt_q <= '0;
    else if (counting)                  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      if (refresh)        stage_q <= 1'b0;
      else if (ovf_first) stage_q <= 1'b1;
      if (ovf_second)     halt_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pulse_q <= '0;
    else if (ovf_second)   pulse_q <= PW'(RST_PULSE_LEN);
    else if (pulse_q != 0) pulse_q <= pulse_q - 1'b1;
  end

  assign rst_req = (pulse_q != '0);
  assign stage   = stage_q;
  assign halted  = halt_q;
endmodule

// File: rtl/two_stage_wdt.sv
`timescale 1ns/1ps
module two_stage_wdt
  import wdt_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int PRESCALE_LOG2 = 20,
  parameter int RST_PULSE_LEN = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk_bus,
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [NUM_CH-1:0] ch_bus;
  logic [NUM_CH-1:0] ch_osc;
  logic              en_sh;
  logic [SET_W-1:0]  set_sh;
  logic              clr_wr;
  logic              ovf_first;
  logic              ovf_second;
  logic              ovf_evt_bus;
  logic              stage;
  logic              halted;

  assign clr_wr = ch_bus[CH_CLR];

  wdt_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk      (clk_bus),
    .rst_n    (rst_n),
    .wr_en    (bus_wr_en),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .ovf_evt  (ovf_evt_bus),
    .rdata    (bus_rdata),
    .irq      (irq_o),
    .en_sh    (en_sh),
    .set_sh   (set_sh),
    .ch_pulse (ch_bus)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_down
    wdt_xfer #(.STAGES(SYNC_STAGES)) xfer_i (
      .src_clk   (clk_bus),
      .dst_clk   (clk_osc),
      .rst_n     (rst_n),
      .src_pulse (ch_bus[c]),
      .dst_pulse (ch_osc[c])
    );
  end

  wdt_xfer #(.STAGES(SYNC_STAGES)) up_i (
    .src_clk   (clk_osc),
    .dst_clk   (clk_bus),
    .rst_n     (rst_n),
    .src_pulse (ovf_first),
    .dst_pulse (ovf_evt_bus)
  );

  wdt_core #(
    .PRESCALE_LOG2 (PRESCALE_LOG2),
    .RST_PULSE_LEN (RST_PULSE_LEN)
  ) core_i (
    .clk        (clk_osc),
    .rst_n      (rst_n),
    .ld_ctrl    (ch_osc[CH_CTRL]),
    .ld_set     (ch_osc[CH_SET]),
    .ld_cnt     (ch_osc[CH_CNT]),
    .refresh    (ch_osc[CH_CLR]),
    .en_in      (en_sh),
    .set_in     (set_sh),
    .ovf_first  (ovf_first),
    .ovf_second (ovf_second),
    .stage      (stage),
    .halted     (halted),
    .rst_req    (rst_req_o)
  );
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk_bus,
  input logic              clk_osc,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              irq_o,
  input logic              rst_req_o,
  input logic              clr_wr,
  input logic              ovf_evt_bus,
  input logic              en_sh,
  input logic              ovf_first,
  input logic              ovf_second,
  input logic              halted
);
  a_r2_set_low_zero: assert property (@(posedge clk_bus) disable iff (!rst_n)
    (bus_addr == ADDR_W'(4)) |-> (bus_rdata[19:0] == 20'd0));

  a_r4_ovf_sets_irq: assert property (@(posedge clk_bus) disable iff (!rst_n)
    (ovf_evt_bus && !clr_wr) |=> irq_o);

  a_r6_clear_drops_irq: assert property (@(posedge clk_bus) disable iff (!rst_n)
    clr_wr |=> !irq_o);

  a_r9_enable_sticky: assert property (@(posedge clk_bus) disable iff (!rst_n)
    en_sh |=> en_sh);

  a_r5_pulse_after_second: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $rose(rst_req_o) |-> $past(ovf_second));

  a_r10_halt_holds: assert property (@(posedge clk_osc) disable iff (!rst_n)
    halted |=> (halted && !ovf_first && !ovf_second));
endmodule

bind two_stage_wdt wdt_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk_bus     (clk_bus),
  .clk_osc     (clk_osc),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .irq_o       (irq_o),
  .rst_req_o   (rst_req_o),
  .clr_wr      (clr_wr),
  .ovf_evt_bus (ovf_evt_bus),
  .en_sh       (en_sh),
  .ovf_first   (ovf_first),
  .ovf_second  (ovf_second),
  .halted      (halted)
);

// File: tb/two_stage_wdt_tb_top.sv
`timescale 1ns/1ps
module two_stage_wdt_tb_top;
  localparam int PS    = 4;
  localparam int PULSE = 5;
  // bound of 6 osc + 9 bus cycles, in osc cycles (bus 10 ns, osc 14 ns), plus 1 for sampling
  localparam int TOL   = 6 + 7 + 1;
  localparam int TOL_I = TOL + 5;   // interrupt also crosses back to the bus clock

  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_SET  = 4'h4;
  localparam logic [3:0] A_CNT  = 4'h8;
  localparam logic [3:0] A_INT  = 4'hC;

  logic        clk_bus = 1'b0;
  logic        clk_osc = 1'b0;
  logic        rst_n   = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [3:0]  bus_addr  = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        rst_req_o;

  always #5 clk_bus = ~clk_bus;
  always #7 clk_osc = ~clk_osc;

  two_stage_wdt #(
    .ADDR_W(4), .PRESCALE_LOG2(PS), .RST_PULSE_LEN(PULSE), .SYNC_STAGES(2)
  ) dut_i (
    .clk_bus(clk_bus), .clk_osc(clk_osc), .rst_n(rst_n),
    .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  longint osc_cnt = 0;
  longint t_wr = 0, t_irq = 0, t_rst = 0;
  int    irq_rises = 0, rst_rises = 0;
  int    cur_w = 0, last_w = 0;
  logic  irq_prev = 1'b0, rst_prev = 1'b0;

  always @(negedge clk_osc) begin
    osc_cnt++;
    if (rst_req_o && !rst_prev) begin rst_rises++; t_rst = osc_cnt; end
    if (rst_req_o) cur_w++;
    if (!rst_req_o && rst_prev) begin last_w = cur_w; cur_w = 0; end
    rst_prev = rst_req_o;
  end

  always @(negedge clk_bus) begin
    if (irq_o && !irq_prev) begin irq_rises++; t_irq = osc_cnt; end
    irq_prev = irq_o;
  end

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input longint act, input longint lo, input longint hi);
    n_checks++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_bus);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_bus);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d; t_wr = osc_cnt;
    @(negedge clk_bus);
    bus_wr_en = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_bus);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk_bus);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic wait_irq(input int base);
    for (int k = 0; k < 3000 && irq_rises == base; k++) @(negedge clk_bus);
  endtask

  task automatic wait_rst(input int base);
    for (int k = 0; k < 3000 && rst_rises == base; k++) @(negedge clk_bus);
  endtask

  initial begin
    repeat (150000) @(negedge clk_bus);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int i0, r0;
    longint t0, per;
    int sweep [7] = '{0, 1, 2, 3, 4, 5, 31};

    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    bus_read(A_CTRL, rd); chk_eq("R1 ctrl", rd, 0);
    bus_read(A_SET, rd);  chk_eq("R1 set", rd, 0);
    bus_read(A_INT, rd);  chk_eq("R1 int", rd, 0);
    chk_eq("R1 irq_o", irq_o, 0);
    chk_eq("R1 rst_req_o", rst_req_o, 0);

    // R2 layout and read-back
    bus_write(A_SET, 32'hFFFF_FFFF);
    bus_read(A_SET, rd); chk_eq("R2 set all ones", rd, 32'hFFF0_0000);
    bus_write(A_SET, 32'h0055_ABCD);
    bus_read(A_SET, rd); chk_eq("R2 set partial", rd, 32'h0050_0000);
    bus_write(A_CNT, 32'h1234_5678);
    bus_read(A_CNT, rd); chk_eq("R2 count reads zero", rd, 0);

    // R12 no counting while disabled
    do_reset();
    i0 = irq_rises; r0 = rst_rises;
    bus_write(A_SET, 32'h0);
    idle(300);
    chk_eq("R12 no irq when disabled", irq_rises - i0, 0);
    chk_eq("R12 no reset when disabled", rst_rises - r0, 0);

    // R3 R5 R8 sweep over settings
    for (int i = 0; i < 7; i++) begin
      per = longint'(sweep[i] + 1) * 16;
      do_reset();
      bus_write(A_SET, sweep[i] << 20);
      idle(20);
      i0 = irq_rises; r0 = rst_rises;
      bus_write(A_CTRL, 32'h1);
      t0 = t_wr;
      bus_read(A_CTRL, rd); chk_eq("R2 enable readback", rd, 1);
      wait_rst(r0);
      chk_eq("R4 one irq rise", irq_rises - i0, 1);
      chk_rng("R3 first overflow time", t_irq - t0, per, per + TOL_I);
      chk_rng("R5 R8 reset time", t_rst - t0, 2 * per, 2 * per + TOL);
      idle(20);
      chk_eq("R5 pulse width", last_w, PULSE);
      chk_eq("R4 irq still high", irq_o, 1);
      if (sweep[i] == 2) begin
        r0 = rst_rises;
        idle(400);
        chk_eq("R10 no second pulse", rst_rises - r0, 0);
      end
    end

    // R6 refresh keeps alive, then two-stage restart
    per = 64;
    do_reset();
    bus_write(A_SET, 32'd3 << 20);
    idle(20);
    i0 = irq_rises; r0 = rst_rises;
    bus_write(A_CTRL, 32'h1);
    for (int k = 0; k < 12; k++) begin
      idle(18);
      bus_write(A_INT, 32'h1);
    end
    chk_eq("R6 no irq while refreshed", irq_rises - i0, 0);
    chk_eq("R6 no reset while refreshed", rst_rises - r0, 0);
    wait_irq(i0);
    chk_eq("R4 irq after refresh stops", irq_o, 1);
    bus_read(A_INT, rd); chk_eq("R4 status bit", rd, 1);
    bus_write(A_INT, 32'h0);
    idle(1);
    chk_eq("R6 write zero ignored", irq_o, 1);
    bus_write(A_INT, 32'h1);
    t0 = t_wr;
    chk_eq("R6 irq cleared next edge", irq_o, 0);
    bus_read(A_INT, rd); chk_eq("R6 status cleared", rd, 0);
    wait_rst(r0);
    chk_rng("R6 reset restarts from refresh", t_rst - t0, 2 * per, 2 * per + TOL);

    // R7 count write restarts the period
    do_reset();
    bus_write(A_SET, 32'd3 << 20);
    idle(20);
    i0 = irq_rises;
    bus_write(A_CTRL, 32'h1);
    idle(40);
    bus_write(A_CNT, 32'h0);
    t0 = t_wr;
    wait_irq(i0);
    chk_rng("R7 irq after count write", t_irq - t0, per, per + TOL_I);

    // R9 enable cannot be cleared
    do_reset();
    bus_write(A_SET, 32'd1 << 20);
    idle(20);
    r0 = rst_rises;
    bus_write(A_CTRL, 32'h1);
    idle(5);
    bus_write(A_CTRL, 32'h0);
    bus_read(A_CTRL, rd); chk_eq("R9 enable stays set", rd, 1);
    wait_rst(r0);
    chk_eq("R9 reset still fires", rst_rises - r0, 1);

    // R11 module reset mid-count
    do_reset();
    bus_write(A_SET, 32'd3 << 20);
    idle(20);
    bus_write(A_CTRL, 32'h1);
    idle(60);
    do_reset();
    bus_read(A_CTRL, rd); chk_eq("R11 ctrl cleared", rd, 0);
    bus_read(A_SET, rd);  chk_eq("R11 set cleared", rd, 0);
    chk_eq("R11 irq cleared", irq_o, 0);
    i0 = irq_rises; r0 = rst_rises;
    idle(400);
    chk_eq("R11 no irq after reset", irq_rises - i0, 0);
    chk_eq("R11 no pulse after reset", rst_rises - r0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule